// File: doc/BRIEF.md
# Privilege Mode Controller

This block holds the current privilege level of a small hart that implements machine mode always and, under parameter control, supervisor and user modes. Each cycle the surrounding pipeline may present one decoded operation: an environment call, a trap entry, a machine or supervisor return, a wait-for-interrupt, a CSR access, or an address-translation fence. Along with it come the trap-delegation hint and three status bits: trap-on-supervisor-return, timeout-wait and trap-virtual-memory.

The block decides whether the operation is allowed in the current mode. If it is, the block updates the current mode and the saved previous-mode fields (a two-bit machine field and a one-bit supervisor field) on the clock edge that accepts the operation. If it is not, the block leaves all mode state untouched. It raises a registered illegal-instruction flag for one cycle, and the trap unit then handles the exception. Trap vectors, cause and return-address registers, interrupt arbitration and translation are handled elsewhere.

Top module: `priv_mode_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block is reset. After that edge `mode_o` = 11 (machine), `mpp_o` = the least privileged implemented mode (00 when user mode exists), `spp_o` = 0 and `illegal_o` = 0.
- R2: `mode_o` uses 00 = user, 01 = supervisor, 11 = machine. The code 10 is never produced, and a mode whose parameter is off is never entered.
- R3: An environment call (op 001) or trap entry (op 111) that goes to machine mode sets `mode_o` to 11 and loads `mpp_o` with the mode that was left.
- R4: When `trap_deleg` = 1, supervisor mode exists and the current mode is below machine, an op 001 or op 111 enters supervisor mode. `spp_o` becomes 1 if the mode left was supervisor and 0 if it was user. From machine mode the delegation hint is ignored, so a trap never lowers the privilege.
- R5: A machine return (op 010) in machine mode moves `mode_o` to the value of `mpp_o` and resets `mpp_o` to the least privileged implemented mode. In any lower mode it is illegal.
- R6: A supervisor return (op 011) is legal in machine mode, and in supervisor mode when `st_tsr` = 0. It moves to supervisor if `spp_o` = 1 and to user otherwise, then clears `spp_o`. It is illegal in user mode, and in supervisor mode when `st_tsr` = 1.
- R7: A wait-for-interrupt (op 100) is illegal below machine mode when `st_tw` = 1. It is legal in machine mode whatever the value of `st_tw`, and legal in every mode when `st_tw` = 0. It does not change the mode.
- R8: A CSR access (op 101) is illegal when the current mode encoding is lower than `csr_addr[9:8]`.
- R9: A CSR write (op 101, `csr_write` = 1) whose `csr_addr[11:10]` = 11 is illegal in every mode. A read of such an address is allowed.
- R10: With `st_tvm` = 1 in supervisor mode, a CSR access to the translation-base address (default 0x180) or a translation fence (op 110) is illegal. A translation fence is always illegal in user mode. Machine mode is never affected.
- R11: `illegal_o` is high exactly in the cycle after an accepted (`instr_valid` = 1) illegal operation. An illegal operation, op 000, or a cycle with `instr_valid` = 0 leaves `mode_o`, `mpp_o` and `spp_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An operation is presented and accepted this cycle |
| instr_op | input | 3 | Operation code (see requirements) |
| trap_deleg | input | 1 | Trap is delegated to supervisor mode |
| csr_addr | input | CSR_AW (12) | Address of the CSR being accessed |
| csr_write | input | 1 | The CSR access writes |
| st_tsr | input | 1 | Status: trap supervisor return |
| st_tw | input | 1 | Status: timeout wait |
| st_tvm | input | 1 | Status: trap virtual-memory operations |
| mode_o | output | 2 | Current privilege mode |
| mpp_o | output | 2 | Machine previous-privilege field |
| spp_o | output | 1 | Supervisor previous-privilege field |
| illegal_o | output | 1 | Registered illegal-instruction flag |

## Verification
The bench builds the block with its defaults: supervisor and user modes both present, a 12-bit CSR address and the translation-base address at 0x180. This makes all three modes and every permission rule reachable. One walk of the vector table therefore covers delegated and undelegated traps out of each mode, nested supervisor traps that set the saved supervisor bit, and returns that restore machine, supervisor and user modes. It also covers the TSR, TW and TVM refusals next to the same operations being allowed once the bit is cleared. Directed cases then cover an idle cycle, the one-cycle width of the illegal flag, and a reset taken out of user mode.

// File: rtl/priv_pkg.sv
// Package: shared encodings for the privilege mode controller.
// Assumes a two-bit privilege encoding and a three-bit decoded operation.
package priv_pkg;

    typedef enum logic [1:0] {
        MODE_U = 2'b00,
        MODE_S = 2'b01,
        MODE_H = 2'b10,
        MODE_M = 2'b11
    } priv_mode_e;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_ECALL  = 3'd1,
        OP_MRET   = 3'd2,
        OP_SRET   = 3'd3,
        OP_WFI    = 3'd4,
        OP_CSR    = 3'd5,
        OP_VFENCE = 3'd6,
        OP_TRAP   = 3'd7
    } priv_op_e;

endpackage

// File: rtl/priv_legal.sv
// Module: priv_legal
// Purely combinational permission check for one decoded operation.
// Assumes the top CSR address bits hold the read-only code and the two
// bits below them hold the minimum privilege. Status bits that have no
// meaning for the implemented modes are treated as zero.
module priv_legal
    import priv_pkg::*;
#(
    parameter int             S_EN       = 1,
    parameter int             U_EN       = 1,
    parameter int             CSR_AW     = 12,
    parameter logic [CSR_AW-1:0] XLATE_CSR = 12'h180
)(
    input  priv_mode_e          mode,
    input  priv_op_e            op,
    input  logic [CSR_AW-1:0]   csr_addr,
    input  logic                csr_write,
    input  logic                tsr,
    input  logic                tw,
    input  logic                tvm,
    output logic                illegal
);
    localparam int RO_HI   = CSR_AW - 1;
    localparam int RO_LO   = CSR_AW - 2;
    localparam int PRIV_HI = CSR_AW - 3;
    localparam int PRIV_LO = CSR_AW - 4;
    localparam bit HAS_S   = (S_EN != 0);
    localparam bit HAS_LOW = (S_EN != 0) || (U_EN != 0);

    logic [1:0] mode_bits;
    logic [1:0] need_bits;
    logic       ro_addr;
    logic       tsr_e, tw_e, tvm_e;

    // Field extraction and masking of status bits by implemented modes
    always_comb begin
        mode_bits = mode;
        need_bits = csr_addr[PRIV_HI:PRIV_LO];
        ro_addr   = (csr_addr[RO_HI:RO_LO] == 2'b11);
        tsr_e     = HAS_S & tsr;
        tw_e      = HAS_LOW & tw;
        tvm_e     = HAS_S & tvm;
    end

    // Legality decision per operation
    always_comb begin
        illegal = 1'b0;
        case (op)
            OP_MRET:   illegal = (mode != MODE_M);
            OP_SRET:   illegal = !HAS_S || (mode == MODE_U) ||
                                 ((mode == MODE_S) && tsr_e);
            OP_WFI:    illegal = tw_e && (mode != MODE_M);
            OP_CSR:    illegal = (mode_bits < need_bits) ||
                                 (csr_write && ro_addr) ||
                                 (tvm_e && (mode == MODE_S) &&
                                  (csr_addr == XLATE_CSR));
            OP_VFENCE: illegal = (mode == MODE_U) ||
                                 (tvm_e && (mode == MODE_S));
            default:   illegal = 1'b0;
        endcase
    end

endmodule

// File: rtl/priv_next.sv
// Module: priv_next
// Computes the next mode and previous-mode fields for an accepted,
// legal operation. Assumes supervisor mode is only built with user mode;
// otherwise returns fall back to the least implemented mode.
module priv_next
    import priv_pkg::*;
#(
    parameter int S_EN = 1,
    parameter int U_EN = 1
)(
    input  logic       valid,
    input  logic       illegal,
    input  priv_op_e   op,
    input  logic       deleg,
    input  priv_mode_e mode,
    input  priv_mode_e mpp,
    input  logic       spp,
    output priv_mode_e mode_n,
    output priv_mode_e mpp_n,
    output logic       spp_n
);
    localparam priv_mode_e LEAST = (U_EN != 0) ? MODE_U : MODE_M;
    localparam bit         HAS_S = (S_EN != 0);

    logic to_sup;

    // Delegation only applies below machine mode (traps never go down)
    assign to_sup = HAS_S && deleg && (mode != MODE_M);

    // Next-state selection per operation
    always_comb begin
        mode_n = mode;
        mpp_n  = mpp;
        spp_n  = spp;
        if (valid && !illegal) begin
            case (op)
                OP_ECALL, OP_TRAP: begin
                    if (to_sup) begin
                        mode_n = MODE_S;
                        spp_n  = (mode == MODE_S);
                    end else begin
                        mode_n = MODE_M;
                        mpp_n  = mode;
                    end
                end
                OP_MRET: begin
                    mode_n = mpp;
                    mpp_n  = LEAST;
                end
                OP_SRET: begin
                    mode_n = spp ? MODE_S : LEAST;
                    spp_n  = 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/priv_mode_ctrl.sv
// Module: priv_mode_ctrl (top)
// Holds the current privilege mode and the saved previous-mode fields,
// and flags illegal operations one cycle after acceptance.
// Assumes a synchronous active-low reset and one operation per cycle.
module priv_mode_ctrl
    import priv_pkg::*;
#(
    parameter int             S_EN       = 1,
    parameter int             U_EN       = 1,
    parameter int             CSR_AW     = 12,
    parameter logic [CSR_AW-1:0] XLATE_CSR = 12'h180
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [2:0]        instr_op,
    input  logic              trap_deleg,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic              csr_write,
    input  logic              st_tsr,
    input  logic              st_tw,
    input  logic              st_tvm,
    output logic [1:0]        mode_o,
    output logic [1:0]        mpp_o,
    output logic              spp_o,
    output logic              illegal_o
);
    localparam priv_mode_e LEAST = (U_EN != 0) ? MODE_U : MODE_M;
    localparam int         RO_HI = CSR_AW - 1;
    localparam int         RO_LO = CSR_AW - 2;

    priv_op_e   op;
    priv_mode_e mode_q, mpp_q, mode_n, mpp_n;
    logic       spp_q, spp_n;
    logic       ill_c, illegal_q;

    assign op = priv_op_e'(instr_op);

    priv_legal #(
        .S_EN(S_EN), .U_EN(U_EN), .CSR_AW(CSR_AW), .XLATE_CSR(XLATE_CSR)
    ) u_legal (
        .mode(mode_q), .op(op), .csr_addr(csr_addr), .csr_write(csr_write),
        .tsr(st_tsr), .tw(st_tw), .tvm(st_tvm), .illegal(ill_c)
    );

    priv_next #(.S_EN(S_EN), .U_EN(U_EN)) u_next (
        .valid(instr_valid), .illegal(ill_c), .op(op), .deleg(trap_deleg),
        .mode(mode_q), .mpp(mpp_q), .spp(spp_q),
        .mode_n(mode_n), .mpp_n(mpp_n), .spp_n(spp_n)
    );

    // Mode, machine previous mode and illegal flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_M;
            mpp_q     <= LEAST;
            illegal_q <= 1'b0;
        end else begin
            mode_q    <= mode_n;
            mpp_q     <= mpp_n;
            illegal_q <= instr_valid && ill_c;
        end
    end

    // Supervisor previous-mode bit only exists with supervisor mode
    generate
        if (S_EN != 0) begin : g_spp
            always_ff @(posedge clk) begin
                if (!rst_n) spp_q <= 1'b0;
                else        spp_q <= spp_n;
            end
        end else begin : g_no_spp
            assign spp_q = 1'b0;
        end
    endgenerate

    assign mode_o    = mode_q;
    assign mpp_o     = mpp_q;
    assign spp_o     = spp_q;
    assign illegal_o = illegal_q;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_q == MODE_M) && (mpp_q == LEAST) && !illegal_q);

    // R2
    mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_H) && ((S_EN != 0) || (mode_q != MODE_S)));

    // R3
    ecall_machine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && op == OP_ECALL && !(trap_deleg && S_EN != 0 && mode_q != MODE_M))
        |=> (mode_q == MODE_M) && (mpp_q == $past(mode_q)));

    // R4
    trap_not_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && (op == OP_TRAP || op == OP_ECALL) && mode_q == MODE_M)
        |=> mode_q == MODE_M);

    // R5
    mret_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && op == OP_MRET && mode_q != MODE_M)
        |=> illegal_q && $stable(mode_q) && $stable(mpp_q));

    // R9
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && op == OP_CSR && csr_write && csr_addr[RO_HI:RO_LO] == 2'b11)
        |=> illegal_q);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(mode_q) && $stable(mpp_q) && $stable(spp_q) && !illegal_q);

endmodule

// File: tb/tb_priv_mode_ctrl.sv
module tb_priv_mode_ctrl;

    typedef struct packed {
        logic [2:0]  op;
        logic [11:0] addr;
        logic        wr;
        logic        dlg;
        logic        tsr;
        logic        tw;
        logic        tvm;
        logic [1:0]  e_mode;
        logic [1:0]  e_mpp;
        logic        e_spp;
        logic        e_ill;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    // Walked in order from reset; each row is one accepted operation.
    localparam vec_t VECS [NV] = '{
        '{3'd2, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd5},  // R5 mret M->U
        '{3'd5, 12'h300, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 4'd8},  // R8 machine csr from U
        '{3'd5, 12'hC00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd9},  // R9 ro read ok
        '{3'd5, 12'hC00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 4'd9},  // R9 ro write
        '{3'd2, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 4'd5},  // R5 mret in U
        '{3'd3, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 4'd6},  // R6 sret in U
        '{3'd6, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 4'd10}, // R10 fence in U
        '{3'd4, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 4'd7},  // R7 wfi tw=1 U
        '{3'd4, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd7},  // R7 wfi tw=0 U
        '{3'd1, 12'h000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 4'd4},  // R4 ecall U->S
        '{3'd5, 12'h180, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 4'd10}, // R10 xlate csr tvm
        '{3'd5, 12'h180, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 4'd8},  // R8 S csr in S
        '{3'd5, 12'h300, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 4'd8},  // R8 M csr in S
        '{3'd6, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0, 1'b0, 1'b1, 4'd10}, // R10 fence tvm=1
        '{3'd6, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 4'd10}, // R10 fence tvm=0
        '{3'd3, 12'h000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 4'd6},  // R6 sret tsr=1
        '{3'd7, 12'h000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b1, 1'b0, 4'd4},  // R4 trap S->S
        '{3'd3, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 4'd6},  // R6 sret to S
        '{3'd1, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd1, 1'b0, 1'b0, 4'd3},  // R3 ecall S->M
        '{3'd5, 12'h300, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd1, 1'b0, 1'b0, 4'd8},  // R8 M csr write
        '{3'd5, 12'hF14, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd1, 1'b0, 1'b1, 4'd9},  // R9 ro write in M
        '{3'd7, 12'h000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 2'd3, 1'b0, 1'b0, 4'd4},  // R4 deleg ignored in M
        '{3'd2, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 1'b0, 1'b0, 4'd5},  // R5 mret to M
        '{3'd4, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 2'd0, 1'b0, 1'b0, 4'd7},  // R7 wfi tw=1 in M
        '{3'd7, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd3, 1'b0, 1'b0, 4'd3},  // R3 trap M->M
        '{3'd2, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 1'b0, 1'b0, 4'd5},  // R5 mret
        '{3'd3, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd6},  // R6 sret M->U
        '{3'd7, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 1'b0, 1'b0, 4'd3},  // R3 trap U->M
        '{3'd0, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 1'b0, 1'b0, 4'd11}  // R11 op none
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [2:0]  instr_op = 3'd0;
    logic        trap_deleg = 1'b0;
    logic [11:0] csr_addr = 12'h000;
    logic        csr_write = 1'b0;
    logic        st_tsr = 1'b0;
    logic        st_tw = 1'b0;
    logic        st_tvm = 1'b0;
    logic [1:0]  mode_o, mpp_o;
    logic        spp_o, illegal_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    priv_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
        .trap_deleg(trap_deleg), .csr_addr(csr_addr), .csr_write(csr_write),
        .st_tsr(st_tsr), .st_tw(st_tw), .st_tvm(st_tvm),
        .mode_o(mode_o), .mpp_o(mpp_o), .spp_o(spp_o), .illegal_o(illegal_o)
    );

    task automatic check(input string what, input int req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input int req, input logic [1:0] m, input logic [1:0] p,
                             input logic s, input logic il);
        check("mode", req, mode_o, m);
        check("mpp", req, mpp_o, p);
        check("spp", req, spp_o, s);
        check("illegal", req, illegal_o, il);
    endtask

    // Drive at a falling edge, let one rising edge pass, sample 2 ns later
    task automatic apply(input logic v, input logic [2:0] op, input logic [11:0] a,
                         input logic w, input logic d, input logic ts,
                         input logic tw, input logic tv);
        instr_valid = v; instr_op = op; csr_addr = a; csr_write = w;
        trap_deleg = d; st_tsr = ts; st_tw = tw; st_tvm = tv;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check_all(1, 2'd3, 2'd0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(1'b1, VECS[i].op, VECS[i].addr, VECS[i].wr, VECS[i].dlg,
                  VECS[i].tsr, VECS[i].tw, VECS[i].tvm);
            check_all(VECS[i].req, VECS[i].e_mode, VECS[i].e_mpp,
                      VECS[i].e_spp, VECS[i].e_ill);
            // R2 the reserved code never appears
            check("mode not 10", 2, (mode_o == 2'b10), 0);
        end

        // R11 machine return presented without valid is ignored
        @(negedge clk);
        apply(1'b0, 3'd2, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_all(11, 2'd3, 2'd0, 1'b0, 1'b0);

        // R5 machine return into user mode
        @(negedge clk);
        apply(1'b1, 3'd2, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_all(5, 2'd0, 2'd0, 1'b0, 1'b0);

        // R11 illegal flag is a single-cycle pulse
        @(negedge clk);
        apply(1'b1, 3'd2, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_all(11, 2'd0, 2'd0, 1'b0, 1'b1);
        @(negedge clk);
        apply(1'b0, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_all(11, 2'd0, 2'd0, 1'b0, 1'b0);

        // R1 reset taken from user mode with a delegated trap pending
        @(negedge clk);
        rst_n = 1'b0;
        apply(1'b1, 3'd7, 12'h000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check_all(1, 2'd3, 2'd0, 1'b0, 1'b0);
        @(negedge clk);
        instr_valid = 1'b0;
        rst_n = 1'b1;

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule